// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A general-purpose I/O port for up to 32 pins, controlled over a simple synchronous register bus. Each pin has an output latch, a drive-enable bit and a synchronized input sample. Software never changes a latch or enable bit with a plain write. It writes a mask to a set address or to a clear address, and only the bits that are 1 in the mask change. Two agents can therefore manage different pins without a read-modify-write sequence.

Input pads pass through a two-flop synchronizer before software can read them. The latch drives the pad output, and the enable bit drives the pad's output-enable. A pin whose enable is 0 is left high-impedance by the pad cell. Bit n of every register belongs to pin n. Read data is combinational from the presented address. A write takes effect at the clock edge that samples the strobe.

Top module: `setclr_gpio`

## Requirements
- R1: While reset (rstN low) is sampled, every output latch bit is cleared and every enable bit is cleared, so padOut and padOe read all zero after the edge.
- R2: A write to offset 0x00 sets to 1 every latch bit whose write-data bit is 1. All other latch bits keep their value.
- R3: A write to offset 0x10 clears to 0 every latch bit whose write-data bit is 1. All other latch bits keep their value.
- R4: A write to offset 0x20 sets the enable bit of every pin whose write-data bit is 1. All other enable bits keep their value.
- R5: A write to offset 0x30 clears the enable bit (tristates the pin) of every pin whose write-data bit is 1. All other enable bits keep their value.
- R6: A read of offset 0x40 returns the synchronized pin levels, bit n for pin n. A padIn change set up before clock edge k is not visible after edge k and is visible after edge k+1.
- R7: Reads of offsets 0x00 and 0x10 return the latch bits. Reads of offsets 0x20 and 0x30 return the enable bits.
- R8: Reads of any other offset return zero. Writes to offset 0x40 or to any unmapped offset change neither latches nor enables, and a cycle without a write changes neither.
- R9: padOut bit n equals latch bit n and padOe bit n equals enable bit n, so a pin is driven with its latch value only while its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, one write per cycle it is high |
| busWdata | input | 32 | Write mask/data, bit n for pin n |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Pad output levels (latch bits) |
| padOe | output | 32 | Pad output enables, 1 drives the pin |

## Verification
On every cycle the assertions check that each set or clear write changes exactly the masked bits of the latch or enable vector, that writes to the input offset, to unmapped offsets or no write at all leave both vectors unchanged, and that a read of the input offset equals the pad level from two edges earlier. Reset clearing is also checked as a property. The read-back decode for every offset, the zero returned for unmapped offsets, and the exact edge at which a pad change becomes visible are shown only by the bench's directed scenarios and its random mix of writes and reads against a reference model.

// File: rtl/gpio_sc_pkg.sv
`timescale 1ns/1ps
package gpio_sc_pkg;

  localparam int unsigned OFF_SET_OUT = 32'h00;
  localparam int unsigned OFF_CLR_OUT = 32'h10;
  localparam int unsigned OFF_SET_OE  = 32'h20;
  localparam int unsigned OFF_CLR_OE  = 32'h30;
  localparam int unsigned OFF_PINS    = 32'h40;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_LATCH  = 2'd1,
    RD_ENABLE = 2'd2,
    RD_PINS   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   setOut;
    logic   clrOut;
    logic   setOe;
    logic   clrOe;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_sc_ctrl.sv
`timescale 1ns/1ps
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe = '{setOut: 1'b0, clrOut: 1'b0, setOe: 1'b0, clrOe: 1'b0, rdSel: RD_ZERO};
    case (busAddr)
      ADDR_W'(OFF_SET_OUT): begin
        strobe.setOut = busWe;
        strobe.rdSel  = RD_LATCH;
      end
      ADDR_W'(OFF_CLR_OUT): begin
        strobe.clrOut = busWe;
        strobe.rdSel  = RD_LATCH;
      end
      ADDR_W'(OFF_SET_OE): begin
        strobe.setOe = busWe;
        strobe.rdSel = RD_ENABLE;
      end
      ADDR_W'(OFF_CLR_OE): begin
        strobe.clrOe = busWe;
        strobe.rdSel = RD_ENABLE;
      end
      ADDR_W'(OFF_PINS): begin
        strobe.rdSel = RD_PINS;
      end
      default: begin
        strobe.rdSel = RD_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/gpio_sc_dpath.sv
`timescale 1ns/1ps
module gpio_sc_dpath
  import gpio_sc_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [DATA_W-1:0]    busRdata
);

  localparam int PAD_BITS = DATA_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] outLatch;
  logic [PIN_COUNT-1:0] driveEn;
  logic [PIN_COUNT-1:0] syncMeta;
  logic [PIN_COUNT-1:0] syncPins;
  logic [PIN_COUNT-1:0] pinMask;

  assign pinMask = busWdata[PIN_COUNT-1:0];

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outLatch[p] <= 1'b0;
        driveEn[p]  <= 1'b0;
        syncMeta[p] <= 1'b0;
        syncPins[p] <= 1'b0;
      end else begin
        if (strobe.setOut && pinMask[p]) outLatch[p] <= 1'b1;
        else if (strobe.clrOut && pinMask[p]) outLatch[p] <= 1'b0;
        if (strobe.setOe && pinMask[p]) driveEn[p] <= 1'b1;
        else if (strobe.clrOe && pinMask[p]) driveEn[p] <= 1'b0;
        syncMeta[p] <= padIn[p];
        syncPins[p] <= syncMeta[p];
      end
    end
  end

  assign padOut = outLatch;
  assign padOe  = driveEn;

  logic [PIN_COUNT-1:0] rdPins;
  always_comb begin
    case (strobe.rdSel)
      RD_LATCH:  rdPins = outLatch;
      RD_ENABLE: rdPins = driveEn;
      RD_PINS:   rdPins = syncPins;
      default:   rdPins = '0;
    endcase
  end

  if (PAD_BITS > 0) begin : g_wide
    assign busRdata = {{PAD_BITS{1'b0}}, rdPins};
  end else begin : g_exact
    assign busRdata = rdPins;
  end

endmodule

// File: rtl/setclr_gpio.sv
`timescale 1ns/1ps
module setclr_gpio
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);

  ctrlStrobe_t strobe;

  gpio_sc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_sc_dpath #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/gpio_sc_chk.sv
`timescale 1ns/1ps
module gpio_sc_chk
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PIN_COUNT = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    busRdata,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe
);

  logic [PIN_COUNT-1:0] wMask;
  logic isSetOut, isClrOut, isSetOe, isClrOe, isMapped;
  logic [1:0] liveCycles;

  assign wMask    = busWdata[PIN_COUNT-1:0];
  assign isSetOut = busWe && (busAddr == ADDR_W'(OFF_SET_OUT));
  assign isClrOut = busWe && (busAddr == ADDR_W'(OFF_CLR_OUT));
  assign isSetOe  = busWe && (busAddr == ADDR_W'(OFF_SET_OE));
  assign isClrOe  = busWe && (busAddr == ADDR_W'(OFF_CLR_OE));
  assign isMapped = isSetOut || isClrOut || isSetOe || isClrOe;

  always_ff @(posedge clk) begin
    if (!rstN) liveCycles <= 2'd0;
    else if (liveCycles != 2'd3) liveCycles <= liveCycles + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (1'b0)
    !rstN |=> (padOut == '0 && padOe == '0));

  // R2
  set_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSetOut |=> padOut == ($past(padOut) | $past(wMask)));

  // R3
  clr_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    isClrOut |=> padOut == ($past(padOut) & ~$past(wMask)));

  // R4
  set_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    isSetOe |=> padOe == ($past(padOe) | $past(wMask)));

  // R5
  clr_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    isClrOe |=> padOe == ($past(padOe) & ~$past(wMask)));

  // R6
  pin_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCycles == 2'd3 && busAddr == ADDR_W'(OFF_PINS))
      |-> busRdata[PIN_COUNT-1:0] == $past(padIn, 2));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |=> ($stable(padOut) && $stable(padOe)));

endmodule

bind setclr_gpio gpio_sc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/setclr_gpio_test.sv
`timescale 1ns/1ps
module setclr_gpio_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int checks = 0;
  int errors = 0;
  logic [31:0] mLatch = '0;
  logic [31:0] mEn = '0;
  logic [31:0] hist1 = '0;
  logic [31:0] hist2 = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    hist1 <= padIn;
    hist2 <= hist1;
  end

  setclr_gpio uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void modelWrite(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: mLatch = mLatch | d;
      8'h10: mLatch = mLatch & ~d;
      8'h20: mEn = mEn | d;
      8'h30: mEn = mEn & ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00, 8'h10: return mLatch;
      8'h20, 8'h30: return mEn;
      8'h40: return hist2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    busWe = 1'b0; busAddr = a;
    #0.5;
    check(req, busRdata, exp);
  endtask

  task automatic padCheck(input string req);
    check({req, " padOut"}, padOut, mLatch);
    check({req, " padOe"}, padOe, mEn);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 padOut", padOut, 32'h0);
    check("R1 padOe", padOe, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck("R1 latch read", 8'h00, 32'h0);
    readCheck("R1 enable read", 8'h20, 32'h0);

    // R2 set keeps other bits
    doWrite(8'h00, 32'h0000_00F0); padCheck("R2");
    doWrite(8'h00, 32'h8000_0001); padCheck("R2");
    check("R2 value", padOut, 32'h8000_00F1);
    // R3 clear only masked bits
    doWrite(8'h10, 32'h0000_0030); padCheck("R3");
    check("R3 value", padOut, 32'h8000_00C1);
    doWrite(8'h10, 32'h0);        padCheck("R3 zero mask");
    // R4 / R5 enables
    doWrite(8'h20, 32'hFFFF_0000); padCheck("R4");
    check("R4 value", padOe, 32'hFFFF_0000);
    doWrite(8'h30, 32'h00FF_0000); padCheck("R5");
    check("R5 value", padOe, 32'hFF00_0000);
    // R9 pad pins follow latch and enable per bit
    check("R9 pin31 out", {31'h0, padOut[31]}, 32'h1);
    check("R9 pin31 oe", {31'h0, padOe[31]}, 32'h1);
    check("R9 pin0 oe", {31'h0, padOe[0]}, 32'h0);
    // R7 read back
    readCheck("R7 0x00", 8'h00, mLatch);
    readCheck("R7 0x10", 8'h10, mLatch);
    readCheck("R7 0x20", 8'h20, mEn);
    readCheck("R7 0x30", 8'h30, mEn);
    // R8 unmapped reads and ignored writes
    readCheck("R8 read 0x04", 8'h04, 32'h0);
    readCheck("R8 read 0x50", 8'h50, 32'h0);
    readCheck("R8 read 0xFF", 8'hFF, 32'h0);
    doWrite(8'h40, 32'hFFFF_FFFF); padCheck("R8 write 0x40");
    doWrite(8'h08, 32'hFFFF_FFFF); padCheck("R8 write 0x08");
    doWrite(8'h11, 32'hFFFF_FFFF); padCheck("R8 write 0x11");

    // R6 two-edge input latency
    padIn = 32'hA5A5_0F0F;
    repeat (3) @(negedge clk);
    padIn = 32'h5A5A_F0F0;
    readCheck("R6 before edge", 8'h40, 32'hA5A5_0F0F);
    @(negedge clk);
    readCheck("R6 after one edge", 8'h40, 32'hA5A5_0F0F);
    @(negedge clk);
    readCheck("R6 after two edges", 8'h40, 32'h5A5A_F0F0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] ra;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: a = 8'h00; 1: a = 8'h10; 2: a = 8'h20; 3: a = 8'h30;
        4: a = 8'h40; default: a = 8'($urandom);
      endcase
      d = $urandom;
      padIn = $urandom;
      doWrite(a, d);
      padCheck("R9 random");
      ra = ($urandom_range(0, 5) == 5) ? 8'($urandom) : 8'($urandom_range(0, 4) * 16);
      readCheck("R7 R8 R6 random read", ra, modelRead(ra));
    end

    // R1 reset again clears everything
    doWrite(8'h00, 32'hFFFF_FFFF);
    doWrite(8'h20, 32'hFFFF_FFFF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mLatch = '0; mEn = '0;
    padCheck("R1 re-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule